// File: doc/BRIEF.md
# Watchdog Timer with Two-Stage Software Clear

This block is the watchdog of a small microcontroller core. It counts ticks from one of two sources chosen by a static option: a free-running slow tick that arrives asynchronously, or the core clock divided by four. If software does not clear it in time, it overflows and asks for a reset. The CPU, the oscillators, and the program counter and stack registers are outside the block. The block only says which kind of reset applies.

Software clears are deliberately coarse. They zero only the two most significant active stages of the divider, so the time-out after a clear lands anywhere in a window between one and two nominal periods. An option can require a pair of distinct clear strobes, in either order, before a clear takes effect. A time-out while running asks for a full chip reset and sets a status flag. A time-out while the core is halted asks only for a warm reset, which restarts the program counter and stack pointer. A guard state machine has four states. GS_OFF means disabled or held by the external reset. GS_RUN means counting. GS_CHIP and GS_WARM each last one cycle and drive the matching request. The machine moves GS_OFF to GS_RUN on enable, GS_RUN to GS_CHIP or GS_WARM on overflow, either fire state back to GS_RUN, and any state to GS_OFF when disabled or held in reset. The clear-pair state machine has three states: PAIR_IDLE, PAIR_GOT_FIRST and PAIR_GOT_SECOND. It completes the pair from either waiting state, or from PAIR_IDLE when both strobes arrive together.

Top module: `wdt_guard`

## Requirements
- R1: With `opt_src_rc`=0 the count source ticks once every 4 clock cycles, with the first tick on the 4th rising edge after the external reset is released. With `opt_src_rc`=1 it ticks once per rising edge of `rc_tick_async`, counting two clock edges after the first edge that samples the input high.
- R2: `opt_tap` value t (0..3) selects stage N = TAP_BASE + t. From a fully cleared counter, the time-out occurs on source tick number 2^(N+1).
- R3: A software clear zeros divider stages N and N+1 and keeps the lower N stages. After a clear with T ticks counted, the time-out therefore comes on tick T + 2^(N+1) - (T mod 2^N), which lies between 2^N and 2^(N+1) ticks after the clear.
- R4: With `opt_dual`=0, a single `clr_single` strobe clears, and `clr_first` and `clr_second` have no effect.
- R5: With `opt_dual`=1, a clear happens only once both `clr_first` and `clr_second` have been seen, in either order or in the same cycle. Either strobe alone does not clear, and `clr_single` has no effect.
- R6: `halt_cmd` and a low `ext_res_n` clear every divider stage and any pending half of a pair. `ext_res_n` low also restarts the divide-by-4 prescaler.
- R7: A time-out with `halted`=0 gives a one-cycle `chip_rst_req` pulse, sets `to_flag` in the same cycle, and never coincides with `warm_rst_req`.
- R8: A time-out with `halted`=1 gives a one-cycle `warm_rst_req` pulse and leaves `to_flag` unchanged.
- R9: `to_flag` is cleared by `ext_res_n` low, by `halt_cmd`, and by any software clear that takes effect.
- R10: With `opt_enable`=0, no reset request is ever produced, and the clear and halt strobes have no effect (`to_flag` keeps its value).
- R11: With the divided core clock as source, counting stops while `halted`=1 and resumes from the same point when it drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_res_n | input | 1 | External reset pin level, active low, synchronous |
| rc_tick_async | input | 1 | Free-running slow tick, asynchronous to clk |
| opt_enable | input | 1 | Option: watchdog enabled |
| opt_src_rc | input | 1 | Option: 1 = slow tick source, 0 = clock divided by 4 |
| opt_tap | input | 2 | Option: time-out stage select |
| opt_dual | input | 1 | Option: 1 = two-strobe clear required |
| clr_single | input | 1 | Single clear instruction strobe |
| clr_first | input | 1 | First half of the paired clear |
| clr_second | input | 1 | Second half of the paired clear |
| halt_cmd | input | 1 | HALT instruction strobe |
| halted | input | 1 | Core is in the halt state |
| chip_rst_req | output | 1 | One-cycle full chip reset request |
| warm_rst_req | output | 1 | One-cycle warm reset request |
| to_flag | output | 1 | Time-out status flag |

## Verification
A divider that loses or keeps the wrong stages on a clear does not fail at the clear itself. It shows up only as a reset request on the wrong edge, up to two nominal periods later. The bench therefore computes the exact edge of every expected pulse and compares the measured edge count. A pair machine stuck in a waiting state shows as a clear that takes effect on one strobe, or never takes effect, and is seen at the next time-out. A guard state machine in the wrong state shows on the very next cycle as a request lasting longer than one cycle, the wrong request kind, or a status flag out of step.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

    typedef enum logic [1:0] {
        PAIR_IDLE,
        PAIR_GOT_FIRST,
        PAIR_GOT_SECOND
    } pair_state_t;

    typedef enum logic [1:0] {
        GS_OFF,
        GS_RUN,
        GS_CHIP,
        GS_WARM
    } guard_state_t;

endpackage

// File: rtl/wdt_tick_src.sv
module wdt_tick_src #(
    parameter int PRE_DIV     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_res_n,
    input  logic enable,
    input  logic src_rc,
    input  logic halted,
    input  logic rc_async,
    output logic tick
);
    localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(PRE_DIV - 1);

    logic [SYNC_STAGES:0] sync_q;
    logic                 rc_edge;
    logic                 instr_tick;

    // synchronizer plus one extra flop for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-1:0], rc_async};
        end
    end

    assign rc_edge = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

    generate
        if (PRE_DIV > 1) begin : g_prescale
            logic [PW-1:0] pre_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pre_q <= '0;
                end else if (!ext_res_n || !enable) begin
                    pre_q <= '0;
                end else if (!src_rc && !halted) begin
                    pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
                end
            end

            assign instr_tick = !halted && (pre_q == PRE_LAST);
        end else begin : g_direct
            assign instr_tick = !halted;
        end
    endgenerate

    always_comb begin
        tick = 1'b0;
        if (enable && ext_res_n) begin
            tick = src_rc ? rc_edge : instr_tick;
        end
    end

endmodule

// File: rtl/wdt_pair_fsm.sv
module wdt_pair_fsm
    import wdt_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic dual,
    input  logic clr_single,
    input  logic clr_first,
    input  logic clr_second,
    input  logic flush,
    input  logic timeout,
    output logic soft_clr
);
    pair_state_t state_q;
    pair_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PAIR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        soft_clr = 1'b0;
        if (!enable || flush) begin
            state_d = PAIR_IDLE;
        end else if (!dual) begin
            soft_clr = clr_single;
            state_d  = PAIR_IDLE;
        end else begin
            unique case (state_q)
                PAIR_IDLE: begin
                    if (clr_first && clr_second) begin
                        soft_clr = 1'b1;
                    end else if (clr_first) begin
                        state_d = PAIR_GOT_FIRST;
                    end else if (clr_second) begin
                        state_d = PAIR_GOT_SECOND;
                    end
                end
                PAIR_GOT_FIRST: begin
                    if (clr_second) begin
                        soft_clr = 1'b1;
                        state_d  = PAIR_IDLE;
                    end
                end
                PAIR_GOT_SECOND: begin
                    if (clr_first) begin
                        soft_clr = 1'b1;
                        state_d  = PAIR_IDLE;
                    end
                end
                default: state_d = PAIR_IDLE;
            endcase
            if (timeout) begin
                state_d = PAIR_IDLE;
            end
        end
    end

endmodule

// File: rtl/wdt_div_chain.sv
module wdt_div_chain #(
    parameter int TAP_BASE = 12,
    parameter int SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             soft_clr,
    input  logic             full_clr,
    input  logic [SEL_W-1:0] tap,
    output logic             expire
);
    localparam int CW = TAP_BASE + (1 << SEL_W) + 1;
    localparam int IW = $clog2(CW + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] stepped;
    logic [CW-1:0] keep;
    logic [IW-1:0] n_idx;
    logic [IW-1:0] top_idx;

    always_comb begin
        n_idx   = IW'(TAP_BASE) + IW'(tap);
        top_idx = n_idx + 1'b1;
        stepped = tick ? cnt_q + 1'b1 : cnt_q;
    end

    generate
        for (genvar i = 0; i < CW; i++) begin : g_keep
            assign keep[i] = (IW'(i) < n_idx);
        end
    endgenerate

    assign expire = tick && !full_clr && !soft_clr && stepped[top_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (full_clr || expire) begin
            cnt_q <= '0;
        end else if (soft_clr) begin
            cnt_q <= stepped & keep;
        end else begin
            cnt_q <= stepped;
        end
    end

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
    import wdt_guard_pkg::*;
#(
    parameter int TAP_BASE = 12,
    parameter int PRE_DIV  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_res_n,
    input  logic       rc_tick_async,
    input  logic       opt_enable,
    input  logic       opt_src_rc,
    input  logic [1:0] opt_tap,
    input  logic       opt_dual,
    input  logic       clr_single,
    input  logic       clr_first,
    input  logic       clr_second,
    input  logic       halt_cmd,
    input  logic       halted,
    output logic       chip_rst_req,
    output logic       warm_rst_req,
    output logic       to_flag
);
    guard_state_t state_q;
    guard_state_t state_d;
    logic         tick;
    logic         soft_clr;
    logic         full_clr;
    logic         expire;
    logic         live;

    assign live     = opt_enable && ext_res_n;
    assign full_clr = !opt_enable || !ext_res_n || halt_cmd;

    wdt_tick_src #(.PRE_DIV(PRE_DIV), .SYNC_STAGES(2)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_res_n(ext_res_n),
        .enable   (opt_enable),
        .src_rc   (opt_src_rc),
        .halted   (halted),
        .rc_async (rc_tick_async),
        .tick     (tick)
    );

    wdt_pair_fsm u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (opt_enable),
        .dual      (opt_dual),
        .clr_single(clr_single),
        .clr_first (clr_first),
        .clr_second(clr_second),
        .flush     (full_clr),
        .timeout   (expire),
        .soft_clr  (soft_clr)
    );

    wdt_div_chain #(.TAP_BASE(TAP_BASE), .SEL_W(2)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .soft_clr(soft_clr),
        .full_clr(full_clr),
        .tap     (opt_tap),
        .expire  (expire)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GS_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_OFF:  if (live) state_d = GS_RUN;
            GS_RUN:  if (expire) state_d = halted ? GS_WARM : GS_CHIP;
            GS_CHIP: state_d = expire ? (halted ? GS_WARM : GS_CHIP) : GS_RUN;
            GS_WARM: state_d = expire ? (halted ? GS_WARM : GS_CHIP) : GS_RUN;
            default: state_d = GS_OFF;
        endcase
        if (!live) begin
            state_d = GS_OFF;
        end
    end

    always_comb begin
        chip_rst_req = (state_q == GS_CHIP);
        warm_rst_req = (state_q == GS_WARM);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            to_flag <= 1'b0;
        end else if (!ext_res_n) begin
            to_flag <= 1'b0;
        end else if (state_d == GS_CHIP) begin
            to_flag <= 1'b1;
        end else if (opt_enable && (halt_cmd || soft_clr)) begin
            to_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic ext_res_n,
    input logic opt_enable,
    input logic halted,
    input logic chip_rst_req,
    input logic warm_rst_req,
    input logic to_flag
);
    p_chip_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst_req |=> !chip_rst_req);

    p_chip_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst_req |-> to_flag);

    p_req_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(chip_rst_req && warm_rst_req));

    p_warm_when_halted_r8: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst_req |-> $past(halted));

    p_warm_keeps_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst_req |-> (to_flag == $past(to_flag)));

    p_off_is_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !opt_enable |=> (!chip_rst_req && !warm_rst_req));

    p_ext_clears_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_res_n |=> !to_flag);

endmodule

bind wdt_guard wdt_guard_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ext_res_n   (ext_res_n),
    .opt_enable  (opt_enable),
    .halted      (halted),
    .chip_rst_req(chip_rst_req),
    .warm_rst_req(warm_rst_req),
    .to_flag     (to_flag)
);

// File: tb/wdt_guard_tb_top.sv
`timescale 1ns/1ps
module wdt_guard_tb_top;
    localparam int TB_BASE = 2;
    localparam int NV      = 14;

    typedef struct packed {
        logic [1:0] tap;
        logic       dual;
        logic [2:0] kind;   // 0 none,1 single,2 first->second,3 second->first,4 first only,5 halt,6 both
        logic [8:0] c1;
        logic [8:0] c2;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 3'd0, 9'd0,   9'd0},
        '{2'd1, 1'b0, 3'd0, 9'd0,   9'd0},
        '{2'd2, 1'b0, 3'd0, 9'd0,   9'd0},
        '{2'd3, 1'b0, 3'd0, 9'd0,   9'd0},
        '{2'd0, 1'b0, 3'd1, 9'd21,  9'd0},
        '{2'd1, 1'b0, 3'd1, 9'd40,  9'd0},
        '{2'd3, 1'b0, 3'd1, 9'd150, 9'd0},
        '{2'd1, 1'b1, 3'd1, 9'd20,  9'd0},
        '{2'd1, 1'b1, 3'd2, 9'd10,  9'd36},
        '{2'd2, 1'b1, 3'd3, 9'd12,  9'd70},
        '{2'd1, 1'b1, 3'd4, 9'd20,  9'd0},
        '{2'd0, 1'b0, 3'd5, 9'd17,  9'd0},
        '{2'd2, 1'b1, 3'd6, 9'd66,  9'd0},
        '{2'd1, 1'b0, 3'd2, 9'd10,  9'd36}
    };

    logic       clk = 1'b0;
    logic       rst_n, ext_res_n, rc_tick_async, opt_enable, opt_src_rc, opt_dual;
    logic [1:0] opt_tap;
    logic       clr_single, clr_first, clr_second, halt_cmd, halted;
    logic       chip_rst_req, warm_rst_req, to_flag;
    int         n_tests = 0;
    int         n_fail  = 0;
    bit         done    = 1'b0;

    always #5 clk = ~clk;

    wdt_guard #(.TAP_BASE(TB_BASE), .PRE_DIV(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .ext_res_n(ext_res_n), .rc_tick_async(rc_tick_async),
        .opt_enable(opt_enable), .opt_src_rc(opt_src_rc), .opt_tap(opt_tap),
        .opt_dual(opt_dual), .clr_single(clr_single), .clr_first(clr_first),
        .clr_second(clr_second), .halt_cmd(halt_cmd), .halted(halted),
        .chip_rst_req(chip_rst_req), .warm_rst_req(warm_rst_req), .to_flag(to_flag)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_edge(input vec_t v);
        int n    = TB_BASE + int'(v.tap);
        int top  = 1 << (n + 1);
        int t0   = 4 * top;
        int cs;
        int t;
        case (v.kind)
            3'd1: cs = v.dual ? -1 : int'(v.c1);
            3'd2, 3'd3: cs = v.dual ? int'(v.c2) : -1;
            3'd6: cs = v.dual ? int'(v.c1) : -1;
            3'd5: return 4 * (int'(v.c1) / 4 + top);
            default: cs = -1;
        endcase
        if (cs < 0) return t0;
        t = cs / 4;
        return 4 * (t + top - (t % (1 << n)));
    endfunction

    function automatic string req_of(input vec_t v);
        case (v.kind)
            3'd0: return "R2";
            3'd1: return v.dual ? "R5" : "R3";
            3'd5: return "R6";
            default: return v.dual ? "R5" : "R4";
        endcase
    endfunction

    task automatic restart_ext();
        @(negedge clk);
        ext_res_n = 1'b0;
        repeat (3) @(negedge clk);
        ext_res_n = 1'b1;
    endtask

    // counts edges from the current negedge until chip_rst_req is seen
    task automatic wait_chip(input int limit, output int edges);
        edges = 0;
        for (int k = 0; k < limit; k++) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            if (chip_rst_req) return;
        end
        edges = -1;
    endtask

    task automatic run_vec(input vec_t v);
        int  edge_n = 0;
        bit  hit    = 1'b0;
        int  exp    = exp_edge(v);
        opt_tap    = v.tap;
        opt_dual   = v.dual;
        opt_src_rc = 1'b0;
        halted     = 1'b0;
        restart_ext();
        while (!hit && edge_n < 2000) begin
            clr_single = (v.kind == 3'd1) && (edge_n + 1 == int'(v.c1));
            clr_first  = ((v.kind == 3'd2 || v.kind == 3'd4 || v.kind == 3'd6) && edge_n + 1 == int'(v.c1))
                      || (v.kind == 3'd3 && edge_n + 1 == int'(v.c2));
            clr_second = ((v.kind == 3'd2) && edge_n + 1 == int'(v.c2))
                      || ((v.kind == 3'd3 || v.kind == 3'd6) && edge_n + 1 == int'(v.c1));
            halt_cmd   = (v.kind == 3'd5) && (edge_n + 1 == int'(v.c1));
            @(posedge clk);
            edge_n++;
            @(negedge clk);
            clr_single = 1'b0; clr_first = 1'b0; clr_second = 1'b0; halt_cmd = 1'b0;
            if (chip_rst_req) hit = 1'b1;
        end
        check(edge_n == exp, req_of(v), "time-out edge", edge_n, exp);
        check(to_flag == 1'b1, "R7", "to_flag after chip time-out", to_flag, 1);
        check(warm_rst_req == 1'b0, "R7", "no warm request", warm_rst_req, 0);
        @(posedge clk);
        @(negedge clk);
        check(chip_rst_req == 1'b0, "R7", "chip request one cycle", chip_rst_req, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual 0 expected 1");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int  edges;
        bit  hit;
        bit  chip_seen;
        int  got_j;
        int  got_p;
        rst_n = 1'b0; ext_res_n = 1'b1; rc_tick_async = 1'b0;
        opt_enable = 1'b1; opt_src_rc = 1'b0; opt_tap = 2'd0; opt_dual = 1'b0;
        clr_single = 1'b0; clr_first = 1'b0; clr_second = 1'b0;
        halt_cmd = 1'b0; halted = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(chip_rst_req == 1'b0, "R7", "reset chip_rst_req", chip_rst_req, 0);
        check(warm_rst_req == 1'b0, "R8", "reset warm_rst_req", warm_rst_req, 0);
        check(to_flag == 1'b0, "R9", "reset to_flag", to_flag, 0);

        // vector table: R2..R6 timing, R1 instruction-clock source
        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i]);
        end

        // R10: disabled, strobes ignored, flag kept
        @(negedge clk);
        opt_enable = 1'b0;
        clr_single = 1'b1;
        @(negedge clk);
        clr_single = 1'b0;
        halt_cmd   = 1'b1;
        @(negedge clk);
        halt_cmd   = 1'b0;
        check(to_flag == 1'b1, "R10", "flag kept while disabled", to_flag, 1);
        chip_seen = 1'b0;
        for (int k = 0; k < 300; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (chip_rst_req || warm_rst_req) chip_seen = 1'b1;
        end
        check(!chip_seen, "R10", "no request while disabled", chip_seen, 0);

        // R9/R6: external reset clears the flag
        opt_enable = 1'b1;
        opt_tap = 2'd0; opt_dual = 1'b0;
        restart_ext();
        check(to_flag == 1'b0, "R9", "flag cleared by ext reset", to_flag, 1'b0);
        wait_chip(500, edges);
        check(edges == 32, "R1", "instruction clock tick period", edges, 32);
        clr_single = 1'b1;
        @(negedge clk);
        clr_single = 1'b0;
        check(to_flag == 1'b0, "R9", "flag cleared by software clear", to_flag, 0);
        wait_chip(500, edges);
        check(to_flag == 1'b1, "R7", "flag set again", to_flag, 1);
        halt_cmd = 1'b1;
        @(negedge clk);
        halt_cmd = 1'b0;
        check(to_flag == 1'b0, "R9", "flag cleared by halt", to_flag, 0);

        // R11: instruction clock source frozen while halted
        halted = 1'b1;
        restart_ext();
        chip_seen = 1'b0;
        for (int k = 0; k < 200; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (chip_rst_req || warm_rst_req) chip_seen = 1'b1;
        end
        check(!chip_seen, "R11", "no count while halted", chip_seen, 0);
        halted = 1'b0;
        wait_chip(500, edges);
        check(edges == 32, "R11", "count resumes after halt", edges, 32);

        // R8 and R1: slow tick source, time-out while halted
        opt_src_rc = 1'b1;
        halted     = 1'b1;
        restart_ext();
        hit = 1'b0; chip_seen = 1'b0; got_j = 0; got_p = 0;
        for (int j = 1; j <= 20; j++) begin
            rc_tick_async = 1'b1;
            for (int p = 1; p <= 4; p++) begin
                @(posedge clk);
                @(negedge clk);
                if (p == 2) rc_tick_async = 1'b0;
                if (warm_rst_req && !hit) begin
                    hit = 1'b1; got_j = j; got_p = p;
                end
                if (chip_rst_req) chip_seen = 1'b1;
            end
        end
        check(got_j == 8, "R8", "warm request on tick 8", got_j, 8);
        check(got_p == 3, "R1", "slow tick two edges after sampling", got_p, 3);
        check(!chip_seen, "R8", "no chip request while halted", chip_seen, 0);
        check(to_flag == 1'b0, "R8", "flag unchanged by warm time-out", to_flag, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule